// File: doc/BRIEF.md
# Integration Test Register Harness

This block is a small APB slave that lets software prove a peripheral is wired correctly into a chip using only bus transfers. It sits between the peripheral core and the rest of the system. The core's functional outputs pass through it on their way out, and the system's inputs to the core pass through it on their way in. A single enable bit turns on test mode. While test mode is on, values written to the test registers replace the functional signals: the intra-chip interrupt and DMA request lines, the primary serial data output, and the two DMA-clear inputs.

What a register read returns depends on the kind of bit being read. Bits that stand for intra-chip lines (the outputs and the DMA-clear inputs) return the live signal after the test multiplexor. This shows either the functional value or the override, whichever is being driven at that moment. The serial-output bit returns the value that was last written to it. The serial-input bit is read-only and shows the level on the pad.

Top module: `apb_itest_harness`

## Requirements
- R1: After reset every test register holds zero, test mode is off, and every multiplexed output equals its functional source.
- R2: The control register is at byte offset 0x180, the input test register at 0x184, output test register 0 at 0x188 and output test register 1 at 0x18C. A write takes effect on the clock edge where PSEL, PENABLE and PWRITE are all high. PREADY is always high and PSLVERR is always low.
- R3: Control bit 0 is the test enable and reads back as written. Control bits 31:1 read as zero.
- R4: Input test bit 2 reads the current level of the serial data input pin. Writes to bit 2 have no effect.
- R5: Input test bits 1 (transmit) and 0 (receive) drive the core's DMA-clear inputs while test mode is on. A read of these bits returns the multiplexor output, which is the system value when test mode is off.
- R6: Output test register 0 bit 29 drives the serial data output pad in test mode and reads back the stored value in both modes. With test mode off, the pad carries the core's serial output.
- R7: Output test register 0 bits 28:0 drive the intra-chip DMA request and interrupt outputs in test mode. A read of these bits returns the multiplexor outputs.
- R8: Output test register 1 bits 12:0 drive the remaining intra-chip interrupt outputs in test mode, with bit 0 as the combined interrupt. A read of these bits returns the multiplexor outputs.
- R9: Unimplemented bits and offsets read as zero. Writes to them are ignored.
- R10: The multiplexors are combinational, so a change of the enable bit changes the driven outputs just after the same clock edge that updates the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always low |
| pad_sdin | input | 1 | Serial data input pad level |
| sys_dmaclr | input | 2 | DMA-clear inputs from system (1 transmit, 0 receive) |
| core_dmaclr | output | 2 | DMA-clear inputs delivered to the core |
| core_sdout | input | 1 | Core serial data output |
| pad_sdout | output | 1 | Serial data output pad |
| core_out0 | input | 29 | Core DMA request and interrupt lines, group 0 |
| sys_out0 | output | 29 | Multiplexed group 0 lines to system |
| core_out1 | input | 13 | Core interrupt lines, group 1 |
| sys_out1 | output | 13 | Multiplexed group 1 lines to system |

## Verification
Two things can happen in one cycle: a register write lands, and the multiplexed outputs switch source. This is most visible when the enable bit is written, because the outputs must flip right after that same edge. The bench samples one time unit after the write edge and compares the pads and intra-chip lines with the override values or with the functional values. It also reads the DMA-clear bits and output group 0 both before and after the switch. This confirms that the live-mux bits follow the mode while the stored serial-output bit does not.

// File: rtl/itest_pkg.sv
package itest_pkg;
   localparam logic [11:0] OFF_CTRL = 12'h180;
   localparam logic [11:0] OFF_IN   = 12'h184;
   localparam logic [11:0] OFF_OUT0 = 12'h188;
   localparam logic [11:0] OFF_OUT1 = 12'h18C;
endpackage

// File: rtl/itest_mux.sv
module itest_mux #(
   parameter int W = 1
) (
   input  logic         sel,
   input  logic [W-1:0] func_val,
   input  logic [W-1:0] test_val,
   output logic [W-1:0] out_val
);
   if (W < 1) begin : g_bad_w
      $error("itest_mux: W must be at least 1");
   end
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign out_val[i] = sel ? test_val[i] : func_val[i];
   end
endmodule

// File: rtl/itest_regfile.sv
module itest_regfile
   import itest_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int IN_W   = 2,
   parameter int OUT0_W = 29,
   parameter int OUT1_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ctrl_en,
   output logic [IN_W-1:0]   in_val,
   output logic              sdout_val,
   output logic [OUT0_W-1:0] out0_val,
   output logic [OUT1_W-1:0] out1_val
);
   localparam int WA = ADDR_W - 2;
   localparam int SDOUT_BIT = OUT0_W;

   logic [WA-1:0] word;
   logic wr_ctrl, wr_in, wr_out0, wr_out1;
   logic unused_wbits;

   assign word    = waddr[ADDR_W-1:2];
   assign wr_ctrl = wr_en && (word == OFF_CTRL[ADDR_W-1:2]);
   assign wr_in   = wr_en && (word == OFF_IN[ADDR_W-1:2]);
   assign wr_out0 = wr_en && (word == OFF_OUT0[ADDR_W-1:2]);
   assign wr_out1 = wr_en && (word == OFF_OUT1[ADDR_W-1:2]);
   assign unused_wbits = ^{waddr[1:0], wdata[DATA_W-1:SDOUT_BIT+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en   <= 1'b0;
         in_val    <= '0;
         sdout_val <= 1'b0;
         out0_val  <= '0;
         out1_val  <= '0;
      end else begin
         if (wr_ctrl) ctrl_en <= wdata[0];
         if (wr_in)   in_val  <= wdata[IN_W-1:0];
         if (wr_out0) begin
            sdout_val <= wdata[SDOUT_BIT];
            out0_val  <= wdata[OUT0_W-1:0];
         end
         if (wr_out1) out1_val <= wdata[OUT1_W-1:0];
      end
   end

   // R3
   ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctrl_en == $past(wdata[0])));
endmodule

// File: rtl/itest_readback.sv
module itest_readback
   import itest_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int IN_W   = 2,
   parameter int OUT0_W = 29,
   parameter int OUT1_W = 13
) (
   input  logic              sel,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              ctrl_en,
   input  logic              sdin_lvl,
   input  logic [IN_W-1:0]   in_live,
   input  logic              sdout_stored,
   input  logic [OUT0_W-1:0] out0_live,
   input  logic [OUT1_W-1:0] out1_live,
   output logic [DATA_W-1:0] rdata
);
   logic [ADDR_W-3:0] word;
   assign word = raddr[ADDR_W-1:2];

   always_comb begin
      rdata = '0;
      if (sel) begin
         if (word == OFF_CTRL[ADDR_W-1:2]) rdata[0] = ctrl_en;
         else if (word == OFF_IN[ADDR_W-1:2]) rdata[IN_W:0] = {sdin_lvl, in_live};
         else if (word == OFF_OUT0[ADDR_W-1:2]) rdata[OUT0_W:0] = {sdout_stored, out0_live};
         else if (word == OFF_OUT1[ADDR_W-1:2]) rdata[OUT1_W-1:0] = out1_live;
      end
   end
endmodule

// File: rtl/apb_itest_harness.sv
module apb_itest_harness
   import itest_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int IN_W   = 2,
   parameter int OUT0_W = 29,
   parameter int OUT1_W = 13
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic              pad_sdin,
   input  logic [IN_W-1:0]   sys_dmaclr,
   output logic [IN_W-1:0]   core_dmaclr,
   input  logic              core_sdout,
   output logic              pad_sdout,
   input  logic [OUT0_W-1:0] core_out0,
   output logic [OUT0_W-1:0] sys_out0,
   input  logic [OUT1_W-1:0] core_out1,
   output logic [OUT1_W-1:0] sys_out1
);
   if (OUT0_W + 1 > DATA_W || OUT1_W > DATA_W || IN_W + 1 > DATA_W) begin : g_bad_width
      $error("apb_itest_harness: register field wider than data bus");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("apb_itest_harness: address too narrow for register offsets");
   end

   logic              wr_en, ten, sd_reg;
   logic [IN_W-1:0]   in_reg;
   logic [OUT0_W-1:0] o0_reg;
   logic [OUT1_W-1:0] o1_reg;

   assign wr_en   = psel && penable && pwrite;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   itest_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_W(IN_W),
                   .OUT0_W(OUT0_W), .OUT1_W(OUT1_W)) u_regs (
      .clk(pclk), .rst_n(presetn), .wr_en(wr_en), .waddr(paddr), .wdata(pwdata),
      .ctrl_en(ten), .in_val(in_reg), .sdout_val(sd_reg),
      .out0_val(o0_reg), .out1_val(o1_reg));

   itest_mux #(.W(IN_W)) u_mux_clr (
      .sel(ten), .func_val(sys_dmaclr), .test_val(in_reg), .out_val(core_dmaclr));
   itest_mux #(.W(1)) u_mux_sd (
      .sel(ten), .func_val(core_sdout), .test_val(sd_reg), .out_val(pad_sdout));
   itest_mux #(.W(OUT0_W)) u_mux_o0 (
      .sel(ten), .func_val(core_out0), .test_val(o0_reg), .out_val(sys_out0));
   itest_mux #(.W(OUT1_W)) u_mux_o1 (
      .sel(ten), .func_val(core_out1), .test_val(o1_reg), .out_val(sys_out1));

   itest_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_W(IN_W),
                    .OUT0_W(OUT0_W), .OUT1_W(OUT1_W)) u_rd (
      .sel(psel), .raddr(paddr), .ctrl_en(ten), .sdin_lvl(pad_sdin),
      .in_live(core_dmaclr), .sdout_stored(sd_reg), .out0_live(sys_out0),
      .out1_live(o1_reg & {OUT1_W{ten}} | core_out1 & {OUT1_W{!ten}}),
      .rdata(prdata));

   logic wr_o0, wr_o1;
   assign wr_o0 = wr_en && (paddr[ADDR_W-1:2] == OFF_OUT0[ADDR_W-1:2]);
   assign wr_o1 = wr_en && (paddr[ADDR_W-1:2] == OFF_OUT1[ADDR_W-1:2]);

   // R7
   out0_override_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_o0 && ten) |=> (sys_out0 == $past(pwdata[OUT0_W-1:0])));
   // R6
   sdout_override_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_o0 && ten) |=> (pad_sdout == $past(pwdata[OUT0_W])));
   // R8
   out1_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (ten && !wr_en) |=> $stable(sys_out1));
   // R9
   hole_read_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && paddr[ADDR_W-1:4] != OFF_CTRL[ADDR_W-1:4]) |-> (prdata == '0));
endmodule

// File: tb/tb_apb_itest_harness.sv
module tb_apb_itest_harness;
   logic        pclk = 1'b0, presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0, prdata;
   logic        pready, pslverr;
   logic        pad_sdin = 1'b1;
   logic [1:0]  sys_dmaclr = 2'b10, core_dmaclr;
   logic        core_sdout = 1'b1, pad_sdout;
   logic [28:0] core_out0 = 29'h0ABC_1234, sys_out0;
   logic [12:0] core_out1 = 13'h1A5C, sys_out1;
   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #2 pclk = ~pclk;

   apb_itest_harness dut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .pad_sdin(pad_sdin), .sys_dmaclr(sys_dmaclr), .core_dmaclr(core_dmaclr),
      .core_sdout(core_sdout), .pad_sdout(pad_sdout), .core_out0(core_out0),
      .sys_out0(sys_out0), .core_out1(core_out1), .sys_out1(sys_out1));

   // {address, write data, expected read}
   localparam logic [75:0] VEC [0:7] = '{
      {12'h180, 32'hFFFF_FFFF, 32'h0000_0001},  // R3
      {12'h188, 32'hFFFF_FFFF, 32'h3FFF_FFFF},  // R7 R6
      {12'h188, 32'h2000_0000, 32'h2000_0000},  // R6
      {12'h18C, 32'hFFFF_FFFF, 32'h0000_1FFF},  // R8
      {12'h18C, 32'h0000_0AAA, 32'h0000_0AAA},  // R8
      {12'h184, 32'hFFFF_FFFF, 32'h0000_0007},  // R4 R5
      {12'h184, 32'h0000_0001, 32'h0000_0005},  // R5
      {12'h190, 32'hFFFF_FFFF, 32'h0000_0000}   // R9
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1'b1;
      @(posedge pclk);
      #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      d = prdata;
      chk("R2 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
      @(posedge pclk);
      #1;
      psel = 1'b0; penable = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(posedge pclk);
      #1 presetn = 1'b1;
      // R1 reset state
      apb_rd(12'h180, rd); chk("R1 ctrl reset", rd, 32'h0);
      apb_rd(12'h184, rd); chk("R1 R5 in reset", rd, 32'h6);
      apb_rd(12'h188, rd); chk("R1 R7 out0 reset", rd, {3'b000, core_out0});
      apb_rd(12'h18C, rd); chk("R1 R8 out1 reset", rd, {19'd0, core_out1});
      chk("R1 outputs functional", {sys_out0, pad_sdout, core_dmaclr},
          {core_out0, core_sdout, sys_dmaclr});
      for (int i = 0; i < 8; i++) begin
         apb_wr(VEC[i][75:64], VEC[i][63:32]);
         apb_rd(VEC[i][75:64], rd);
         chk($sformatf("R2 vector %0d", i), rd, VEC[i][31:0]);
      end
      // test mode: overrides visible
      chk("R7 sys_out0 override", {3'd0, sys_out0}, 32'h0);
      chk("R6 pad_sdout override", {31'd0, pad_sdout}, 32'h1);
      chk("R8 sys_out1 override", {19'd0, sys_out1}, 32'hAAA);
      chk("R5 dmaclr override", {30'd0, core_dmaclr}, 32'h1);
      core_sdout = 1'b0; pad_sdin = 1'b0;
      apb_rd(12'h184, rd); chk("R4 sdin live", rd, 32'h1);
      // R10 leave test mode; outputs switch just after the write edge
      apb_wr(12'h180, 32'h0);
      chk("R10 out1 functional", {19'd0, sys_out1}, {19'd0, core_out1});
      chk("R10 pad functional", {31'd0, pad_sdout}, 32'h0);
      chk("R10 dmaclr functional", {30'd0, core_dmaclr}, 32'h2);
      apb_rd(12'h188, rd); chk("R6 stored readback", rd, {3'b001, core_out0});
      apb_rd(12'h184, rd); chk("R5 live readback", rd, 32'h2);
      apb_wr(12'h184, 32'h3);
      chk("R5 no effect when off", {30'd0, core_dmaclr}, 32'h2);
      apb_wr(12'h180, 32'h1);
      chk("R10 dmaclr re-enable", {30'd0, core_dmaclr}, 32'h3);
      apb_wr(12'h184, 32'h4);
      apb_rd(12'h184, rd); chk("R4 bit2 write ignored", rd, 32'h0);
      apb_wr(12'h1F0, 32'hFFFF_FFFF);
      apb_rd(12'h18C, rd); chk("R9 hole write ignored", rd, 32'hAAA);
      apb_rd(12'h180, rd); chk("R3 ctrl upper zero", rd, 32'h1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule